// File: doc/BRIEF.md
# Byte-Lane FIFO Controller with Sticky Status

This block manages a 64-word, 32-bit FIFO that sits between a processor bus and a serial codec. A direction input chooses who fills and who drains the store. In transmit configuration the bus pushes words and the codec pops them. In receive configuration the codec pushes and the bus pops. Each stored word carries a 4-bit frame-end marker, one bit per byte lane, and a 2-bit tag. Software can load either pointer directly.

A 16-bit status word reports sticky error flags, frame status and the tag of the last word the bus read. Software clears a flag by writing 1 to its bit. A single interrupt output is high while any sticky error flag is set.

In frame mode the block counts complete frames and shows which byte lane of the head word ends a frame. Two codec events act on partial frames. A reject in receive configuration discards a partially received frame. A retry in transmit configuration rewinds the read side to resend the current frame. The block flags an accept error when software has touched data that belongs to such a frame.

Top module: `fifo_status_ctrl`

## Requirements
- R1: Status layout: bit 15 illegal pointer (IP), bit 14 transmit wait (TXW), bits 13:12 last tag, bits 11:8 frame lane, bit 7 frame accept error (FAE), bit 6 receive wait (RXW), bit 5 underflow (UF), bit 4 overflow (OF), bit 3 frame ready, bits 2:0 zero. After reset the whole word is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: Direction and order.
  - With `tx_mode`=1 the bus pushes and the codec pops. With `tx_mode`=0 the codec pushes and the bus pops.
  - Pushes and pops from the side not selected have no effect.
  - Words leave in the order they entered. `fifo_empty` and `fifo_full` are never both high.
- R3: Overflow and underflow.
  - A push while 64 words are held is dropped and sets OF.
  - A pop while empty moves no pointer and sets UF.
- R4: Wait flags.
  - TXW sets when the codec pops while `tx_mode`=1 and the FIFO is empty.
  - RXW sets when the codec pushes while `tx_mode`=0 and the FIFO is full.
- R5: Clearing the sticky flags.
  - IP, TXW, FAE, RXW, UF and OF stay set until a status write with a 1 in their bit. A 0 bit has no effect.
  - A set condition in the same cycle as the clear wins.
- R6: `fifo_irq` is high exactly while any of the six sticky flags is set.
- R7: Pointer loads.
  - A pointer load with a value of 128 or more sets IP and leaves that pointer unchanged.
  - A value below 128 is loaded. Bit 6 of a pointer is the wrap bit.
- R8: Frame ready.
  - A word whose end marker is non-zero closes a frame.
  - Frame ready is 1 only in frame mode while at least one complete frame is stored. It returns to 0 once all complete frames have been popped.
- R9: Frame lane field.
  - In frame mode with data present, bits 11:8 show the head word's end marker. Bit 11 is lane [31:24], bit 10 is lane [23:16], bit 9 is lane [15:8] and bit 8 is lane [7:0].
  - Otherwise the field is 0.
- R10: Reject (receive configuration, frame mode).
  - `cdc_reject` rewinds the write pointer to the start of the partial frame.
  - If the bus had already popped words of that frame, FAE sets and the read pointer also rewinds.
- R11: Retry and overwrite (transmit configuration, frame mode).
  - `cdc_retry` rewinds the read pointer to the first word of the frame being sent.
  - A bus push that lands on a slot of a frame not yet fully popped sets FAE. The push is still stored.
- R12: Every bus-side pop in receive configuration copies the popped word's tag into bits 13:12.
- R13: Outside frame mode, `cdc_retry` and `cdc_reject` have no effect and FAE never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 1: transmit configuration, 0: receive configuration |
| frame_mode | input | 1 | Enables frame tracking |
| bus_push | input | 1 | Bus-side push request |
| bus_wdata | input | 32 | Bus push data |
| bus_wend | input | 4 | Bus push frame-end lane marker |
| bus_wtag | input | 2 | Bus push tag |
| bus_pop | input | 1 | Bus-side pop request |
| cdc_push | input | 1 | Codec push request |
| cdc_wdata | input | 32 | Codec push data |
| cdc_wend | input | 4 | Codec push frame-end lane marker |
| cdc_wtag | input | 2 | Codec push tag |
| cdc_pop | input | 1 | Codec pop request |
| cdc_retry | input | 1 | Codec asks to resend the current frame |
| cdc_reject | input | 1 | Codec discards the frame being received |
| rd_data | output | 32 | Head word data |
| rd_end | output | 4 | Head word end marker |
| fifo_empty | output | 1 | No words held |
| fifo_full | output | 1 | 64 words held |
| ptr_wr_w | input | 1 | Load the write pointer |
| ptr_wr_r | input | 1 | Load the read pointer |
| ptr_val | input | 8 | Pointer load value |
| st_wr | input | 1 | Status write strobe (write 1 to clear) |
| st_wdata | input | 16 | Status write data |
| status | output | 16 | Status word |
| fifo_irq | output | 1 | FIFO error interrupt |

## Verification
The assertions check these rules on every cycle:
- the flags that are stuck on, and the conditions that set overflow, underflow, transmit wait and illegal pointer;
- the interrupt falling only after a status write;
- frame ready and the lane field staying quiet outside frame mode or when empty;
- the accept error staying clear outside frame mode.

Only the bench's scenarios can show the rest:
- word order across a full 64-entry wrap, and that the word pushed while full is really absent;
- the rewind targets after reject and retry, and the overwrite case that needs a nearly full store behind a partly sent frame;
- the tag following each bus read, and that a set in the same cycle as a clear wins.

// File: rtl/fifo_status_ctrl.sv
module fifo_status_ctrl #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int TW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_mode,
  input  logic          frame_mode,
  input  logic          bus_push,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW/8-1:0] bus_wend,
  input  logic [TW-1:0] bus_wtag,
  input  logic          bus_pop,
  input  logic          cdc_push,
  input  logic [DW-1:0] cdc_wdata,
  input  logic [DW/8-1:0] cdc_wend,
  input  logic [TW-1:0] cdc_wtag,
  input  logic          cdc_pop,
  input  logic          cdc_retry,
  input  logic          cdc_reject,
  output logic [DW-1:0] rd_data,
  output logic [DW/8-1:0] rd_end,
  output logic          fifo_empty,
  output logic          fifo_full,
  input  logic          ptr_wr_w,
  input  logic          ptr_wr_r,
  input  logic [$clog2(DEPTH)+1:0] ptr_val,
  input  logic          st_wr,
  input  logic [15:0]   st_wdata,
  output logic [15:0]   status,
  output logic          fifo_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int NL = DW / 8;
  localparam int EW = DW + NL + TW;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, fstart, wstart, fcnt, wptr_n, rptr_n;
  logic [PW-1:0] cnt, dr, dw;
  logic [TW-1:0] tag_q;
  logic ip, txw, fae, rxw, uf, of;

  wire [EW-1:0] head = mem[rptr[AW-1:0]];
  wire [TW-1:0] head_tag = head[TW-1:0];
  assign rd_end  = head[TW +: NL];
  assign rd_data = head[TW+NL +: DW];

  assign cnt = wptr - rptr;
  assign fifo_empty = (cnt == '0);
  assign fifo_full  = (cnt >= PW'(DEPTH));

  wire push_req = tx_mode ? bus_push : cdc_push;
  wire pop_req  = tx_mode ? cdc_pop  : bus_pop;
  wire [EW-1:0] w_ent = tx_mode ? {bus_wdata, bus_wend, bus_wtag}
                                : {cdc_wdata, cdc_wend, cdc_wtag};
  wire push_end = |w_ent[TW +: NL];
  wire pop_end  = |rd_end;
  wire do_push  = push_req && !fifo_full;
  wire do_pop   = pop_req && !fifo_empty;

  wire ptr_ok = (ptr_val < (PW+1)'(2*DEPTH));
  wire ld_w   = ptr_wr_w && ptr_ok;
  wire ld_r   = ptr_wr_r && ptr_ok;
  wire retry  = frame_mode && tx_mode && cdc_retry;
  wire reject = frame_mode && !tx_mode && cdc_reject;

  assign dr = rptr - wstart;
  assign dw = wptr - wstart;
  wire rd_touch = (dr != '0) && (dr <= dw);
  wire ovw = frame_mode && tx_mode && do_push && ((wptr - fstart) >= PW'(DEPTH));

  always_comb begin
    wptr_n = wptr;
    if (ld_w)         wptr_n = ptr_val[PW-1:0];
    else if (reject)  wptr_n = wstart;
    else if (do_push) wptr_n = wptr + 1'b1;
    rptr_n = rptr;
    if (ld_r)                     rptr_n = ptr_val[PW-1:0];
    else if (retry)               rptr_n = fstart;
    else if (reject && rd_touch)  rptr_n = wstart;
    else if (do_pop)              rptr_n = rptr + 1'b1;
  end

  wire inc = do_push && push_end && !reject && !ld_w;
  wire dec = do_pop && pop_end && !retry && !ld_r && !(reject && rd_touch);

  always_ff @(posedge clk)
    if (do_push) mem[wptr[AW-1:0]] <= w_ent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; fstart <= '0; wstart <= '0; fcnt <= '0;
      tag_q <= '0;
      {ip, txw, fae, rxw, uf, of} <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
      if (!frame_mode || ld_r || dec) fstart <= rptr_n;
      if (!frame_mode || ld_w || inc) wstart <= wptr_n;
      fcnt <= fcnt + PW'(inc) - PW'(dec);
      if (do_pop && !tx_mode) tag_q <= head_tag;
      ip  <= (ip  & ~(st_wr & st_wdata[15])) | ((ptr_wr_w | ptr_wr_r) & ~ptr_ok);
      txw <= (txw & ~(st_wr & st_wdata[14])) | (tx_mode & cdc_pop & fifo_empty);
      fae <= (fae & ~(st_wr & st_wdata[7]))  | ovw | (reject & rd_touch);
      rxw <= (rxw & ~(st_wr & st_wdata[6]))  | (~tx_mode & cdc_push & fifo_full);
      uf  <= (uf  & ~(st_wr & st_wdata[5]))  | (pop_req & fifo_empty);
      of  <= (of  & ~(st_wr & st_wdata[4]))  | (push_req & fifo_full);
    end
  end

  wire frdy = frame_mode && (fcnt != '0);
  wire [3:0] lane = (frame_mode && !fifo_empty) ? 4'(rd_end) : 4'b0;
  assign status   = {ip, txw, 2'(tag_q), lane, fae, rxw, uf, of, frdy, 3'b000};
  assign fifo_irq = ip | txw | fae | rxw | uf | of;
endmodule

module fifo_status_ctrl_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_mode,
  input logic        frame_mode,
  input logic        bus_push,
  input logic        bus_pop,
  input logic        cdc_push,
  input logic        cdc_pop,
  input logic        cdc_retry,
  input logic        cdc_reject,
  input logic        fifo_empty,
  input logic        fifo_full,
  input logic        ptr_wr_w,
  input logic        ptr_wr_r,
  input logic [$clog2(DEPTH)+1:0] ptr_val,
  input logic        st_wr,
  input logic [15:0] st_wdata,
  input logic [15:0] status,
  input logic        fifo_irq
);
  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n) !(fifo_empty && fifo_full)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_full && !bus_pop && !cdc_pop && !ptr_wr_w && !ptr_wr_r && !cdc_reject && !cdc_retry |=> fifo_full); // R3
  AST_OF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) tx_mode && bus_push && fifo_full |=> status[4]); // R3
  AST_UF_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !tx_mode && bus_pop && fifo_empty |=> status[5]); // R3
  AST_TXW_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_mode && cdc_pop && fifo_empty |=> status[14]); // R4
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) status[5] && !(st_wr && st_wdata[5]) |=> status[5]); // R5
  AST_OF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) status[4] && !(st_wr && st_wdata[4]) |=> status[4]); // R5
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(fifo_irq) |-> $past(st_wr)); // R6
  AST_IP_ON_BAD_PTR: assert property (@(posedge clk) disable iff (!rst_n) (ptr_wr_w || ptr_wr_r) && ptr_val >= 2*DEPTH |=> status[15]); // R7
  AST_FRDY_MODE: assert property (@(posedge clk) disable iff (!rst_n) !frame_mode |-> !status[3]); // R8
  AST_LANE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) fifo_empty |-> status[11:8] == 4'b0); // R9
  AST_FAE_MODE: assert property (@(posedge clk) disable iff (!rst_n) !frame_mode && !status[7] |=> !status[7]); // R13
endmodule

bind fifo_status_ctrl fifo_status_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .frame_mode(frame_mode),
  .bus_push(bus_push), .bus_pop(bus_pop), .cdc_push(cdc_push), .cdc_pop(cdc_pop),
  .cdc_retry(cdc_retry), .cdc_reject(cdc_reject), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .ptr_wr_w(ptr_wr_w), .ptr_wr_r(ptr_wr_r), .ptr_val(ptr_val),
  .st_wr(st_wr), .st_wdata(st_wdata), .status(status), .fifo_irq(fifo_irq)
);

// File: tb/fifo_status_ctrl_test.sv
module fifo_status_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic tx_mode = 0, frame_mode = 0;
  logic bus_push = 0, bus_pop = 0, cdc_push = 0, cdc_pop = 0, cdc_retry = 0, cdc_reject = 0;
  logic [31:0] bus_wdata = 0, cdc_wdata = 0;
  logic [3:0] bus_wend = 0, cdc_wend = 0;
  logic [1:0] bus_wtag = 0, cdc_wtag = 0;
  logic ptr_wr_w = 0, ptr_wr_r = 0;
  logic [7:0] ptr_val = 0;
  logic st_wr = 0;
  logic [15:0] st_wdata = 0;
  logic [31:0] rd_data;
  logic [3:0] rd_end;
  logic fifo_empty, fifo_full, fifo_irq;
  logic [15:0] status;

  int nchk = 0, nfail = 0;
  bit sb_on = 0;
  logic [31:0] q[$];

  fifo_status_ctrl uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (sb_on && ((!tx_mode && bus_pop) || (tx_mode && cdc_pop)) && !fifo_empty) begin
      if (q.size() == 0) chk("R2 scoreboard underrun", rd_data, 32'hxxxx_xxxx);
      else chk("R2 order", rd_data, q.pop_front());
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic bpush(logic [31:0] d, logic [3:0] e, bit keep);
    @(negedge clk); bus_push = 1; bus_wdata = d; bus_wend = e; bus_wtag = d[1:0];
    if (keep) q.push_back(d);
    @(negedge clk); bus_push = 0;
  endtask

  task automatic cpush(logic [31:0] d, logic [3:0] e, bit keep);
    @(negedge clk); cdc_push = 1; cdc_wdata = d; cdc_wend = e; cdc_wtag = d[1:0];
    if (keep) q.push_back(d);
    @(negedge clk); cdc_push = 0;
  endtask

  task automatic bpop();
    @(negedge clk); bus_pop = 1;
    @(negedge clk); bus_pop = 0;
  endtask

  task automatic cpop();
    @(negedge clk); cdc_pop = 1;
    @(negedge clk); cdc_pop = 0;
  endtask

  task automatic ptr_load(bit wr_side, logic [7:0] v);
    @(negedge clk); ptr_val = v;
    if (wr_side) ptr_wr_w = 1; else ptr_wr_r = 1;
    @(negedge clk); ptr_wr_w = 0; ptr_wr_r = 0;
  endtask

  task automatic st_write(logic [15:0] v);
    @(negedge clk); st_wr = 1; st_wdata = v;
    @(negedge clk); st_wr = 0; st_wdata = 0;
  endtask

  task automatic pulse_reject();
    @(negedge clk); cdc_reject = 1;
    @(negedge clk); cdc_reject = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset status", 32'(status), 0);
    chk("R1 reset irq", 32'(fifo_irq), 0);
    chk("R1 reset empty", 32'(fifo_empty), 1);
    chk("R1 reset full", 32'(fifo_full), 0);

    ptr_load(1, 8'd2);
    chk("R7 legal wptr load", 32'(fifo_empty), 0);
    ptr_load(0, 8'd2);
    chk("R7 legal rptr load", 32'(fifo_empty), 1);
    ptr_load(0, 8'd130);
    chk("R7 IP set", 32'(status[15]), 1);
    chk("R7 pointer unchanged", 32'(fifo_empty), 1);
    chk("R6 irq on IP", 32'(fifo_irq), 1);
    st_write(16'h0000);
    chk("R5 write zero no effect", 32'(status[15]), 1);
    st_write(16'h8000);
    chk("R5 write one clears IP", 32'(status[15]), 0);
    chk("R6 irq low", 32'(fifo_irq), 0);

    sb_on = 1;
    cpush(32'hA000_0001, 4'b0, 1);
    cpush(32'hA000_0002, 4'b0, 1);
    cpush(32'hA000_0003, 4'b0, 1);
    bpop(); chk("R12 tag after pop 1", 32'(status[13:12]), 1);
    bpop(); chk("R12 tag after pop 2", 32'(status[13:12]), 2);
    bpop(); chk("R12 tag after pop 3", 32'(status[13:12]), 3);
    chk("R2 empty after drain", 32'(fifo_empty), 1);

    bpop();
    chk("R3 UF on empty pop", 32'(status[5]), 1);
    chk("R6 irq on UF", 32'(fifo_irq), 1);
    chk("R12 tag kept on empty pop", 32'(status[13:12]), 3);
    st_write(16'h0020);
    chk("R5 UF cleared", 32'(status), 16'h3000);

    bpush(32'h1234_5678, 4'b0, 0);
    chk("R2 bus push ignored in receive", 32'(fifo_empty), 1);
    cpop();
    chk("R4 codec pop ignored in receive", 32'(status & 16'h4020), 0);

    tx_mode = 1;
    cpop();
    chk("R4 TXW on empty codec pop", 32'(status[14]), 1);
    chk("R3 UF with TXW", 32'(status[5]), 1);
    st_write(16'h4020);
    chk("R5 clear TXW and UF", 32'(fifo_irq), 0);

    for (int i = 0; i < 64; i++) bpush(32'(i * 3 + 7), 4'b0, 1);
    chk("R3 full at 64", 32'(fifo_full), 1);
    bpush(32'hDEAD_BEEF, 4'b0, 0);
    chk("R3 OF on full push", 32'(status[4]), 1);
    chk("R3 still full", 32'(fifo_full), 1);
    for (int i = 0; i < 64; i++) cpop();
    chk("R3 dropped word absent", 32'(q.size()), 0);
    chk("R2 empty after transmit drain", 32'(fifo_empty), 1);
    st_write(16'h0010);

    tx_mode = 0;
    for (int i = 0; i < 64; i++) cpush(32'(i * 5 + 4), 4'b0, 1);
    cpush(32'hBAD0_0000, 4'b0, 0);
    chk("R4 RXW on full codec push", 32'(status[6]), 1);
    chk("R3 OF with RXW", 32'(status[4]), 1);
    for (int i = 0; i < 64; i++) bpop();
    chk("R2 receive drain complete", 32'(q.size()), 0);
    st_write(16'h0050);
    chk("R5 clear RXW and OF", 32'(status & 16'hC0F0), 0);

    @(negedge clk); bus_pop = 1; st_wr = 1; st_wdata = 16'h0020;
    @(negedge clk); bus_pop = 0; st_wr = 0; st_wdata = 0;
    chk("R5 set wins over clear", 32'(status[5]), 1);
    st_write(16'h0020);
    sb_on = 0;

    frame_mode = 1;
    cpush(32'hF000_000A, 4'b0000, 0);
    cpush(32'hF000_000B, 4'b0010, 0);
    chk("R8 frame ready after end", 32'(status[3]), 1);
    chk("R9 lane head without end", 32'(status[11:8]), 0);
    bpop();
    chk("R9 lane of head end word", 32'(status[11:8]), 4'b0010);
    chk("R2 head data", rd_data, 32'hF000_000B);
    bpop();
    chk("R8 frame ready clears", 32'(status[3]), 0);
    chk("R9 lane zero when empty", 32'(status[11:8]), 0);

    cpush(32'hF000_000C, 4'b1000, 0);
    cpush(32'hF000_000D, 4'b0001, 0);
    chk("R9 lane top byte", 32'(status[11:8]), 4'b1000);
    bpop();
    chk("R8 frame ready with one left", 32'(status[3]), 1);
    chk("R9 lane bottom byte", 32'(status[11:8]), 4'b0001);
    bpop();
    chk("R8 frame ready after all read", 32'(status[3]), 0);

    cpush(32'hE000_0001, 4'b0, 0);
    cpush(32'hE000_0002, 4'b0, 0);
    bpop();
    pulse_reject();
    chk("R10 FAE on touched reject", 32'(status[7]), 1);
    chk("R10 both pointers rewound", 32'(fifo_empty), 1);
    chk("R6 irq on FAE", 32'(fifo_irq), 1);
    st_write(16'h0080);

    cpush(32'hE000_0003, 4'b0, 0);
    pulse_reject();
    chk("R10 no FAE on untouched reject", 32'(status[7]), 0);
    chk("R10 partial frame discarded", 32'(fifo_empty), 1);
    cpush(32'hE000_0004, 4'b0001, 0);
    chk("R10 next frame at head", rd_data, 32'hE000_0004);
    bpop();

    tx_mode = 1;
    bpush(32'hC000_0001, 4'b0000, 0);
    bpush(32'hC000_0002, 4'b0100, 0);
    cpop();
    chk("R11 head moved before retry", rd_data, 32'hC000_0002);
    @(negedge clk); cdc_retry = 1;
    @(negedge clk); cdc_retry = 0;
    chk("R11 retry rewinds to frame start", rd_data, 32'hC000_0001);
    cpop(); cpop();
    chk("R11 drained after resend", 32'(fifo_empty), 1);
    chk("R8 no frames after resend", 32'(status[3]), 0);

    for (int i = 0; i < 64; i++) bpush(32'(i + 100), 4'b0, 0);
    cpop();
    chk("R11 not full after one pop", 32'(fifo_full), 0);
    chk("R11 no FAE yet", 32'(status[7]), 0);
    bpush(32'h0BAD_0BAD, 4'b0, 0);
    chk("R11 FAE on overwrite of retained frame", 32'(status[7]), 1);
    chk("R11 overwrite stored", 32'(fifo_full), 1);

    do_reset();
    frame_mode = 0; tx_mode = 0;
    cpush(32'h7000_0001, 4'b0000, 0);
    cpush(32'h7000_0002, 4'b0001, 0);
    chk("R8 no frame ready outside frame mode", 32'(status[3]), 0);
    bpop();
    pulse_reject();
    chk("R13 reject ignored FAE", 32'(status[7]), 0);
    chk("R13 reject ignored data", rd_data, 32'h7000_0002);
    chk("R13 reject ignored empty", 32'(fifo_empty), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule